// File: doc/BRIEF.md
# Configuration Request Bus Router

This block decides where a hierarchical configuration request goes inside a bridge. Each request names a bus, a device, a function, a register byte offset and a request type. The block compares the bus number with three programmed bridge numbers: the upstream-side bus, the directly attached downstream bus, and the highest bus reachable below the bridge. From that comparison it picks one of four outcomes. The request is left unclaimed, claimed by the bridge's own functions, rewritten as a same-segment request for the attached downstream bus, or passed further down unchanged.

The result is registered, so it appears one cycle after the request. All outgoing fields are cleared when a request is unclaimed. A claimed request whose offset falls outside the supported configuration space, 256 bytes or 4 KB, carries an error flag. Bus timing, data movement and completion return are handled elsewhere.

Top module: `cfgr_router`

## Requirements
- R1: While reset is low, and on the first cycle after it rises, out_valid, out_route, out_type1, out_bus, out_dev, out_fn, out_off and out_off_err are all zero.
- R2: out_valid in a cycle equals in_valid as sampled at the previous rising clock edge (one register stage).
- R3: A far request (in_type1=1) whose bus equals dn_bus is claimed with route 2'b10 (local). out_type1=0 and bus, device, function and offset are copied unchanged.
- R4: A far request whose bus is greater than dn_bus and not greater than last_bus is claimed with route 2'b11 (forward). out_type1=1 and all fields are copied unchanged.
- R5: A far request whose bus is below dn_bus or above last_bus gives route 2'b00 (none), and all output fields and out_off_err are zero.
- R6: A near request (in_type1=0) whose function number is below NUM_FN (default 1) gets route 2'b01 (self), with out_type1=0 and fields copied.
- R7: A near request whose function number is NUM_FN or higher gives route 2'b00 with zeroed fields.
- R8: out_off_err is 1 exactly when the route is not 2'b00 and in_off is at least the space size (256 with EXT_CFG=0, the default; 4096 with EXT_CFG=1). An unclaimed request never sets it.
- R9: When in_valid is low, the next cycle shows out_valid=0, route 2'b00 and zero fields, whatever the other inputs are.
- R10: When last_bus is below dn_bus, only a bus equal to dn_bus is claimed (route 2'b10). Every other far request gets route 2'b00.
- R11: A far request whose bus equals up_bus gets route 2'b00, even if it lies in the downstream range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_type1 | input | 1 | 1 = far (other segment) request, 0 = near request |
| in_bus | input | BUS_W | Target bus number |
| in_dev | input | DEV_W | Target device number |
| in_fn | input | FN_W | Target function number |
| in_off | input | OFF_W | Register byte offset |
| up_bus | input | BUS_W | Bridge upstream-side bus number |
| dn_bus | input | BUS_W | Bus directly attached below the bridge |
| last_bus | input | BUS_W | Highest bus number reachable below the bridge |
| out_valid | output | 1 | Decision present |
| out_route | output | 2 | 00 none, 01 self, 10 local, 11 forward |
| out_type1 | output | 1 | Type of the outgoing request |
| out_bus | output | BUS_W | Outgoing bus number |
| out_dev | output | DEV_W | Outgoing device number |
| out_fn | output | FN_W | Outgoing function number |
| out_off | output | OFF_W | Outgoing byte offset |
| out_off_err | output | 1 | Offset beyond the supported space on a claimed request |

## Verification
The bench targets the range edges. It uses a bus equal to dn_bus and a bus equal to last_bus, which would show an off-by-one compare: either a local request sent on as far, or the deepest bus dropped. It checks one bus above last_bus and one below dn_bus, which would catch a design that claims traffic it does not own. It programs a reversed range to catch a forward window that wraps. It sends an offset just past 256 bytes, both claimed and unclaimed. A wrong limit compare would miss the error, and a flag not gated by the route would report errors on traffic that was never claimed. A mid-stream reset must clear the registered decision at once.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
    typedef enum logic [1:0] {
        RT_NONE  = 2'b00,
        RT_SELF  = 2'b01,
        RT_LOCAL = 2'b10,
        RT_FWD   = 2'b11
    } route_e;
endpackage

// File: rtl/cfgr_bus_decode.sv
module cfgr_bus_decode
    import cfgr_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int FN_W   = 3,
    parameter int NUM_FN = 1
) (
    input  logic             valid,
    input  logic             type1,
    input  logic [BUS_W-1:0] bus,
    input  logic [FN_W-1:0]  fn,
    input  logic [BUS_W-1:0] up_bus,
    input  logic [BUS_W-1:0] dn_bus,
    input  logic [BUS_W-1:0] last_bus,
    output route_e           route
);
    localparam logic [FN_W:0] FN_LIM = (FN_W+1)'(NUM_FN);

    logic hit_up;
    logic hit_dn;
    logic in_window;
    logic own_fn;

    always_comb begin
        hit_up    = (bus == up_bus);
        hit_dn    = (bus == dn_bus);
        in_window = (bus > dn_bus) && (bus <= last_bus);
        own_fn    = ({1'b0, fn} < FN_LIM);
        route     = RT_NONE;
        if (valid) begin
            if (!type1) begin
                route = own_fn ? RT_SELF : RT_NONE;
            end else if (hit_up) begin
                route = RT_NONE;
            end else if (hit_dn) begin
                route = RT_LOCAL;
            end else if (in_window) begin
                route = RT_FWD;
            end
        end
    end
endmodule

// File: rtl/cfgr_space_limit.sv
module cfgr_space_limit #(
    parameter int OFF_W   = 12,
    parameter bit EXT_CFG = 1'b0
) (
    input  logic [OFF_W-1:0] off,
    output logic             beyond
);
    localparam int SPACE   = EXT_CFG ? 4096 : 256;
    localparam int SPACE_W = $clog2(SPACE);

    generate
        if (OFF_W <= SPACE_W) begin : g_fits
            assign beyond = 1'b0;
        end else begin : g_cmp
            localparam logic [OFF_W-1:0] LIM = OFF_W'(SPACE);
            assign beyond = (off >= LIM);
        end
    endgenerate
endmodule

// File: rtl/cfgr_router.sv
module cfgr_router
    import cfgr_pkg::*;
#(
    parameter int BUS_W   = 8,
    parameter int DEV_W   = 5,
    parameter int FN_W    = 3,
    parameter int OFF_W   = 12,
    parameter int NUM_FN  = 1,
    parameter bit EXT_CFG = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_type1,
    input  logic [BUS_W-1:0] in_bus,
    input  logic [DEV_W-1:0] in_dev,
    input  logic [FN_W-1:0]  in_fn,
    input  logic [OFF_W-1:0] in_off,
    input  logic [BUS_W-1:0] up_bus,
    input  logic [BUS_W-1:0] dn_bus,
    input  logic [BUS_W-1:0] last_bus,
    output logic             out_valid,
    output logic [1:0]       out_route,
    output logic             out_type1,
    output logic [BUS_W-1:0] out_bus,
    output logic [DEV_W-1:0] out_dev,
    output logic [FN_W-1:0]  out_fn,
    output logic [OFF_W-1:0] out_off,
    output logic             out_off_err
);
    typedef struct packed {
        logic             vld;
        route_e           route;
        logic             t1;
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [OFF_W-1:0] off;
        logic             oerr;
    } dec_st_t;

    route_e  route_w;
    logic    beyond_w;
    dec_st_t st_d;
    dec_st_t st_q;

    cfgr_bus_decode #(
        .BUS_W (BUS_W),
        .FN_W  (FN_W),
        .NUM_FN(NUM_FN)
    ) u_decode (
        .valid   (in_valid),
        .type1   (in_type1),
        .bus     (in_bus),
        .fn      (in_fn),
        .up_bus  (up_bus),
        .dn_bus  (dn_bus),
        .last_bus(last_bus),
        .route   (route_w)
    );

    cfgr_space_limit #(
        .OFF_W  (OFF_W),
        .EXT_CFG(EXT_CFG)
    ) u_limit (
        .off   (in_off),
        .beyond(beyond_w)
    );

    always_comb begin
        st_d       = '0;
        st_d.vld   = in_valid;
        st_d.route = route_w;
        if (route_w != RT_NONE) begin
            st_d.t1   = (route_w == RT_FWD);
            st_d.bus  = in_bus;
            st_d.dev  = in_dev;
            st_d.fn   = in_fn;
            st_d.off  = in_off;
            st_d.oerr = beyond_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_route   = st_q.route;
    assign out_type1   = st_q.t1;
    assign out_bus     = st_q.bus;
    assign out_dev     = st_q.dev;
    assign out_fn      = st_q.fn;
    assign out_off     = st_q.off;
    assign out_off_err = st_q.oerr;

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    a_r3_local_is_near: assert property (@(posedge clk) disable iff (!rst_n)
        (out_route == 2'b10) |-> (!out_type1 && out_bus == $past(dn_bus)));

    a_r4_fwd_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (out_route == 2'b11) |-> (out_type1 && out_bus > $past(dn_bus)
                                  && out_bus <= $past(last_bus)));

    a_r5_none_is_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_route == 2'b00) |-> (out_bus == '0 && out_off == '0 && !out_off_err));

    a_r9_idle_no_route: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_route == 2'b00));

    a_r11_never_upstream: assert property (@(posedge clk) disable iff (!rst_n)
        (out_type1) |-> (out_bus != $past(up_bus)));
endmodule

// File: tb/cfgr_router_tb.sv
module cfgr_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_type1 = 1'b0;
    logic [7:0]  in_bus = '0;
    logic [4:0]  in_dev = '0;
    logic [2:0]  in_fn = '0;
    logic [11:0] in_off = '0;
    logic [7:0]  up_bus = '0;
    logic [7:0]  dn_bus = '0;
    logic [7:0]  last_bus = '0;
    logic        out_valid;
    logic [1:0]  out_route;
    logic        out_type1;
    logic [7:0]  out_bus;
    logic [4:0]  out_dev;
    logic [2:0]  out_fn;
    logic [11:0] out_off;
    logic        out_off_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfgr_router dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type1(in_type1),
        .in_bus(in_bus), .in_dev(in_dev), .in_fn(in_fn), .in_off(in_off),
        .up_bus(up_bus), .dn_bus(dn_bus), .last_bus(last_bus),
        .out_valid(out_valid), .out_route(out_route), .out_type1(out_type1),
        .out_bus(out_bus), .out_dev(out_dev), .out_fn(out_fn),
        .out_off(out_off), .out_off_err(out_off_err)
    );

    typedef struct packed {
        logic        t1;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [11:0] off;
        logic [7:0]  up;
        logic [7:0]  dn;
        logic [7:0]  last;
        logic [1:0]  rt;
        logic        err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'd1, 5'd2,  3'd3, 12'h010, 8'd0, 8'd1, 8'd3, 2'b10, 1'b0},
        '{1'b1, 8'd3, 5'd4,  3'd1, 12'h0FC, 8'd0, 8'd1, 8'd3, 2'b11, 1'b0},
        '{1'b1, 8'd2, 5'd7,  3'd0, 12'h100, 8'd0, 8'd1, 8'd3, 2'b11, 1'b1},
        '{1'b1, 8'd4, 5'd1,  3'd2, 12'h020, 8'd0, 8'd1, 8'd3, 2'b00, 1'b0},
        '{1'b1, 8'd0, 5'd1,  3'd2, 12'h020, 8'd5, 8'd1, 8'd3, 2'b00, 1'b0},
        '{1'b0, 8'd0, 5'd9,  3'd0, 12'h040, 8'd0, 8'd1, 8'd3, 2'b01, 1'b0},
        '{1'b0, 8'd0, 5'd9,  3'd2, 12'h040, 8'd0, 8'd1, 8'd3, 2'b00, 1'b0},
        '{1'b0, 8'd0, 5'd3,  3'd0, 12'h200, 8'd0, 8'd1, 8'd3, 2'b01, 1'b1},
        '{1'b1, 8'd5, 5'd6,  3'd4, 12'h008, 8'd0, 8'd5, 8'd2, 2'b10, 1'b0},
        '{1'b1, 8'd6, 5'd6,  3'd4, 12'h008, 8'd0, 8'd5, 8'd2, 2'b00, 1'b0},
        '{1'b1, 8'd2, 5'd8,  3'd1, 12'h004, 8'd2, 8'd1, 8'd3, 2'b00, 1'b0},
        '{1'b1, 8'd4, 5'd8,  3'd1, 12'h300, 8'd0, 8'd1, 8'd3, 2'b00, 1'b0}
    };
    string tags [NV] = '{"R3", "R4", "R8", "R5", "R5", "R6",
                         "R7", "R8", "R10", "R10", "R11", "R8"};

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_clear(input string req);
        chk(req, "valid", 32'(out_valid), 32'd0);
        chk(req, "route", 32'(out_route), 32'd0);
        chk(req, "type1", 32'(out_type1), 32'd0);
        chk(req, "bus",   32'(out_bus),   32'd0);
        chk(req, "dev",   32'(out_dev),   32'd0);
        chk(req, "fn",    32'(out_fn),    32'd0);
        chk(req, "off",   32'(out_off),   32'd0);
        chk(req, "err",   32'(out_off_err), 32'd0);
    endtask

    task automatic drive(input vec_t v);
        in_valid = 1'b1;
        in_type1 = v.t1;
        in_bus   = v.bus;
        in_dev   = v.dev;
        in_fn    = v.fn;
        in_off   = v.off;
        up_bus   = v.up;
        dn_bus   = v.dn;
        last_bus = v.last;
    endtask

    task automatic expect_vec(input vec_t v, input string req);
        logic claimed;
        claimed = (v.rt != 2'b00);
        chk("R2",  "valid", 32'(out_valid), 32'd1);
        chk(req, "route", 32'(out_route), 32'(v.rt));
        chk(req, "type1", 32'(out_type1), 32'(v.rt == 2'b11));
        chk(req, "bus",   32'(out_bus), claimed ? 32'(v.bus) : 32'd0);
        chk(req, "dev",   32'(out_dev), claimed ? 32'(v.dev) : 32'd0);
        chk(req, "fn",    32'(out_fn),  claimed ? 32'(v.fn)  : 32'd0);
        chk(req, "off",   32'(out_off), claimed ? 32'(v.off) : 32'd0);
        chk(req, "err",   32'(out_off_err), 32'(v.err));
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs clear while reset is held, with a request present
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        chk_clear("R1");
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_clear("R1");

        // table walk: drive at one falling edge, check at the next
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            expect_vec(VECS[i], tags[i]);
        end

        // R9: idle with a request pattern that would otherwise be claimed
        drive(VECS[1]);
        in_valid = 1'b0;
        @(negedge clk);
        chk_clear("R9");

        // R2: back-to-back requests, each decided one cycle later
        drive(VECS[0]);
        @(negedge clk);
        expect_vec(VECS[0], "R2");
        drive(VECS[5]);
        @(negedge clk);
        expect_vec(VECS[5], "R2");
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2", "valid drop", 32'(out_valid), 32'd0);

        // R4: deepest bus equal to last_bus is still forwarded
        drive('{1'b1, 8'd9, 5'd31, 3'd7, 12'h0FF, 8'd0, 8'd4, 8'd9, 2'b11, 1'b0});
        @(negedge clk);
        expect_vec('{1'b1, 8'd9, 5'd31, 3'd7, 12'h0FF, 8'd0, 8'd4, 8'd9, 2'b11, 1'b0}, "R4");

        // R1: reset mid-stream clears the held decision at once
        drive(VECS[1]);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_clear("R1");
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_clear("R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule